// File: doc/BRIEF.md
# MSI Vector Request Serializer

This block sits between a set of interrupt sources and a PCIe bridge that accepts message-signalled interrupts one at a time. Each source owns one vector. A one-cycle event on a source marks its vector as pending. The block then offers pending vectors to the bridge one after another. It does this over a pulse handshake: a single-cycle request carries a vector number, and the bridge answers later with a single-cycle grant.

Each vector has a mask input. A masked vector is never offered. Its pending bit stays set, and the vector goes out as soon as its mask drops. When several vectors are eligible, the lowest-numbered one wins. A vector's pending bit is cleared only when the bridge grants that vector. Another request may go out in the same cycle as a grant. The global enable input gates all requests, but it never discards pending state.

Top module: `msi_serializer`

## Requirements
- R1: After synchronous active-high reset, no vector is pending and no request is outstanding, so `req_o` stays low until a new event arrives.
- R2: `req_o` is never high while `msi_en_i` is low. Pending vectors are kept and are requested once `msi_en_i` returns high.
- R3: `req_o` is a single-cycle pulse. After a request, `req_o` stays low until the cycle in which `gnt_i` is high.
- R4: In the cycle where `gnt_i` is high, a request for another eligible vector may be driven at once.
- R5: When several vectors are eligible, the lowest-numbered one is requested first (index 0 has the highest priority).
- R6: A vector whose `mask_i` bit is high is never requested, and it stays pending. In the first cycle its mask is low, it becomes eligible for a request.
- R7: Repeated events on a vector that is already pending or in flight merge into the existing pending state, so only one request results.
- R8: An event on `evt_i` is registered, so the earliest request it can cause is in the next clock cycle.
- R9: A grant clears the pending bit of the vector in flight. An event on that vector in the grant cycle sets the bit again, so that vector is requested once more.
- R10: Whenever `req_o` is high, `vec_o` is below `NUM_VEC`, the vector is pending, and the vector is not masked.
- R11: A `gnt_i` pulse that arrives while no request is outstanding has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | NUM_VEC | Per-vector event pulses |
| mask_i | input | NUM_VEC | Per-vector mask, high = withheld |
| msi_en_i | input | 1 | Global enable for requests |
| req_o | output | 1 | Single-cycle request pulse toward the bridge |
| vec_o | output | VEC_W | Vector number, valid while req_o is high |
| gnt_i | input | 1 | Single-cycle grant from the bridge |

## Verification
Some rules are checked by the assertions on every cycle. These are: a request only while enabled, no second request before a grant, a requested vector that is pending and unmasked, and the pending bit cleared by a grant. Other behaviour can only be shown by the bench's scenarios, which compare the vector order against expected sequences. That covers priority order, merging of repeated events, release of a masked vector on unmask, resumption after re-enable, and re-arming by an event in the grant cycle.

// File: rtl/msi_ser_pkg.sv
package msi_ser_pkg;

  typedef enum logic {ST_IDLE, ST_WAIT} issue_st_e;

  localparam int unsigned MAX_VEC = 64;

  // Index of the lowest set bit, or MAX_VEC if none is set.
  function automatic int unsigned lowest_set(input logic [MAX_VEC-1:0] bits);
    int unsigned r;
    r = MAX_VEC;
    for (int i = MAX_VEC - 1; i >= 0; i--) begin
      if (bits[i]) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/msi_pend_bank.sv
module msi_pend_bank #(
  parameter int unsigned NUM_VEC = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_VEC-1:0] set_i,
  input  logic [NUM_VEC-1:0] clr_i,
  output logic [NUM_VEC-1:0] pend_o
);
  for (genvar g = 0; g < NUM_VEC; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)           pend_o[g] <= 1'b0;
      else if (set_i[g]) pend_o[g] <= 1'b1;
      else if (clr_i[g]) pend_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/msi_prio_pick.sv
module msi_prio_pick #(
  parameter int unsigned NUM_VEC = 8,
  localparam int unsigned VEC_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic [NUM_VEC-1:0] elig_i,
  output logic               any_o,
  output logic [VEC_W-1:0]   idx_o
);
  logic [msi_ser_pkg::MAX_VEC-1:0] wide;
  int unsigned                     pos;

  always_comb begin
    wide = '0;
    wide[NUM_VEC-1:0] = elig_i;
    pos   = msi_ser_pkg::lowest_set(wide);
    any_o = |elig_i;
    idx_o = any_o ? VEC_W'(pos) : '0;
  end
endmodule

// File: rtl/msi_issue_fsm.sv
module msi_issue_fsm #(
  parameter int unsigned NUM_VEC = 8,
  localparam int unsigned VEC_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             gnt_i,
  input  logic             any_i,
  input  logic [VEC_W-1:0] idx_i,
  output logic             req_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             busy_o,
  output logic             retire_o,
  output logic [VEC_W-1:0] infl_o
);
  import msi_ser_pkg::*;

  issue_st_e        st_q;
  logic [VEC_W-1:0] infl_q;
  logic             slot_free;

  always_comb begin
    busy_o    = (st_q == ST_WAIT);
    retire_o  = busy_o && gnt_i;
    slot_free = !busy_o || gnt_i;
    req_o     = slot_free && en_i && any_i;
    vec_o     = idx_i;
    infl_o    = infl_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      infl_q <= '0;
    end else if (req_o) begin
      st_q   <= ST_WAIT;
      infl_q <= idx_i;
    end else if (retire_o) begin
      st_q   <= ST_IDLE;
    end
  end
endmodule

// File: rtl/msi_serializer.sv
module msi_serializer #(
  parameter int unsigned NUM_VEC = 8,
  localparam int unsigned VEC_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_VEC-1:0] evt_i,
  input  logic [NUM_VEC-1:0] mask_i,
  input  logic               msi_en_i,
  output logic               req_o,
  output logic [VEC_W-1:0]   vec_o,
  input  logic               gnt_i
);
  logic [NUM_VEC-1:0] pend_q;
  logic [NUM_VEC-1:0] infl_hot;
  logic [NUM_VEC-1:0] clr_vec;
  logic [NUM_VEC-1:0] elig;
  logic               any_elig;
  logic [VEC_W-1:0]   pick_idx;
  logic               busy;
  logic               retire;
  logic [VEC_W-1:0]   infl_idx;

  always_comb begin
    for (int i = 0; i < NUM_VEC; i++) begin
      infl_hot[i] = busy && (infl_idx == VEC_W'(i));
    end
    clr_vec = retire ? infl_hot : '0;
    elig    = pend_q & ~mask_i & ~infl_hot;
  end

  msi_pend_bank #(.NUM_VEC(NUM_VEC)) u_bank (
    .clk(clk), .rst(rst), .set_i(evt_i), .clr_i(clr_vec), .pend_o(pend_q)
  );

  msi_prio_pick #(.NUM_VEC(NUM_VEC)) u_pick (
    .elig_i(elig), .any_o(any_elig), .idx_o(pick_idx)
  );

  msi_issue_fsm #(.NUM_VEC(NUM_VEC)) u_fsm (
    .clk(clk), .rst(rst), .en_i(msi_en_i), .gnt_i(gnt_i),
    .any_i(any_elig), .idx_i(pick_idx),
    .req_o(req_o), .vec_o(vec_o), .busy_o(busy), .retire_o(retire),
    .infl_o(infl_idx)
  );
endmodule

// File: rtl/msi_serializer_chk.sv
module msi_serializer_chk #(
  parameter int unsigned NUM_VEC = 8,
  localparam int unsigned VEC_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_VEC-1:0] evt_i,
  input logic [NUM_VEC-1:0] mask_i,
  input logic               msi_en_i,
  input logic               req_o,
  input logic [VEC_W-1:0]   vec_o,
  input logic               gnt_i,
  input logic [NUM_VEC-1:0] pend_q,
  input logic               busy,
  input logic [VEC_W-1:0]   infl_idx
);
  // R2
  req_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    req_o |-> msi_en_i);

  // R3
  one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
    req_o |=> (!req_o || gnt_i));

  // R10
  vec_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    req_o |-> (int'(vec_o) < NUM_VEC));

  // R10
  vec_pending_unmasked_chk: assert property (@(posedge clk) disable iff (rst)
    (req_o && int'(vec_o) < NUM_VEC) |-> (pend_q[vec_o] && !mask_i[vec_o]));

  // R9
  grant_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && gnt_i && !req_o && !evt_i[infl_idx]) |=> !pend_q[$past(infl_idx)]);
endmodule

bind msi_serializer msi_serializer_chk #(.NUM_VEC(NUM_VEC)) u_chk (
  .clk(clk), .rst(rst), .evt_i(evt_i), .mask_i(mask_i), .msi_en_i(msi_en_i),
  .req_o(req_o), .vec_o(vec_o), .gnt_i(gnt_i), .pend_q(pend_q),
  .busy(busy), .infl_idx(infl_idx)
);

// File: tb/sim_msi_serializer.sv
module sim_msi_serializer;
  localparam int unsigned N = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] evt, mask;
  logic         en, gnt;
  logic         req;
  logic [2:0]   vec;
  int           n_chk = 0;
  int           n_bad = 0;
  bit           done  = 0;

  always #4 clk = ~clk;

  msi_serializer #(.NUM_VEC(N)) u0 (
    .clk(clk), .rst(rst), .evt_i(evt), .mask_i(mask), .msi_en_i(en),
    .req_o(req), .vec_o(vec), .gnt_i(gnt)
  );

  // Apply inputs for one cycle; outputs are sampled 1 ns later, before the edge.
  task automatic cyc(input logic [N-1:0] e, input logic [N-1:0] m,
                     input logic n, input logic g);
    @(negedge clk);
    evt = e; mask = m; en = n; gnt = g;
    #1;
  endtask

  task automatic expect_req(input string rq, input logic r, input int v);
    n_chk++;
    if (req !== r || (r && int'(vec) != v)) begin
      n_bad++;
      $display("FAIL %s: req=%0b vec=%0d expected req=%0b vec=%0d",
               rq, req, vec, r, v);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1;
    cyc('0, '0, 1'b1, 1'b0);
    cyc('0, '0, 1'b1, 1'b0);
    rst = 1'b0;
    cyc('0, '0, 1'b1, 1'b0); expect_req("R1", 1'b0, 0);
    cyc('0, '0, 1'b1, 1'b0); expect_req("R1", 1'b0, 0);
  endtask

  task automatic t_single;
    cyc(8'h08, '0, 1'b1, 1'b0); expect_req("R8", 1'b0, 0);
    cyc('0,    '0, 1'b1, 1'b0); expect_req("R8", 1'b1, 3);
    cyc('0,    '0, 1'b1, 1'b0); expect_req("R3", 1'b0, 0);
    cyc('0,    '0, 1'b1, 1'b0); expect_req("R3", 1'b0, 0);
    cyc('0,    '0, 1'b1, 1'b1); expect_req("R9", 1'b0, 0);
    cyc('0,    '0, 1'b1, 1'b0); expect_req("R9", 1'b0, 0);
  endtask

  task automatic t_priority;
    cyc(8'h64, '0, 1'b1, 1'b0); expect_req("R8", 1'b0, 0);
    cyc('0,    '0, 1'b1, 1'b0); expect_req("R5", 1'b1, 2);
    cyc('0,    '0, 1'b1, 1'b1); expect_req("R4", 1'b1, 5);
    cyc('0,    '0, 1'b1, 1'b0); expect_req("R3", 1'b0, 0);
    cyc('0,    '0, 1'b1, 1'b1); expect_req("R5", 1'b1, 6);
    cyc('0,    '0, 1'b1, 1'b1); expect_req("R9", 1'b0, 0);
    cyc('0,    '0, 1'b1, 1'b0); expect_req("R9", 1'b0, 0);
  endtask

  task automatic t_mask;
    cyc(8'h02, 8'h02, 1'b1, 1'b0); expect_req("R6", 1'b0, 0);
    for (int i = 0; i < 3; i++) begin
      cyc('0, 8'h02, 1'b1, 1'b0); expect_req("R6", 1'b0, 0);
    end
    cyc('0, '0, 1'b1, 1'b0); expect_req("R6", 1'b1, 1);
    cyc('0, '0, 1'b1, 1'b1); expect_req("R6", 1'b0, 0);
    cyc('0, '0, 1'b1, 1'b0); expect_req("R6", 1'b0, 0);
  endtask

  task automatic t_enable;
    cyc(8'h10, '0, 1'b0, 1'b0); expect_req("R2", 1'b0, 0);
    for (int i = 0; i < 3; i++) begin
      cyc('0, '0, 1'b0, 1'b0); expect_req("R2", 1'b0, 0);
    end
    cyc('0, '0, 1'b1, 1'b0); expect_req("R2", 1'b1, 4);
    cyc('0, '0, 1'b1, 1'b1); expect_req("R2", 1'b0, 0);
  endtask

  task automatic t_merge;
    cyc(8'h80, '0, 1'b1, 1'b0); expect_req("R7", 1'b0, 0);
    cyc(8'h80, '0, 1'b1, 1'b0); expect_req("R7", 1'b1, 7);
    cyc(8'h80, '0, 1'b1, 1'b0); expect_req("R7", 1'b0, 0);
    cyc('0,    '0, 1'b1, 1'b1); expect_req("R7", 1'b0, 0);
    cyc('0,    '0, 1'b1, 1'b0); expect_req("R7", 1'b0, 0);
  endtask

  task automatic t_rearm;
    cyc(8'h01, '0, 1'b1, 1'b0); expect_req("R9", 1'b0, 0);
    cyc('0,    '0, 1'b1, 1'b0); expect_req("R9", 1'b1, 0);
    cyc(8'h01, '0, 1'b1, 1'b1); expect_req("R9", 1'b0, 0);
    cyc('0,    '0, 1'b1, 1'b0); expect_req("R9", 1'b1, 0);
    cyc('0,    '0, 1'b1, 1'b1); expect_req("R9", 1'b0, 0);
  endtask

  task automatic t_stray_grant;
    cyc('0,    '0, 1'b1, 1'b1); expect_req("R11", 1'b0, 0);
    cyc(8'h04, '0, 1'b1, 1'b1); expect_req("R11", 1'b0, 0);
    cyc('0,    '0, 1'b1, 1'b0); expect_req("R11", 1'b1, 2);
    cyc('0,    '0, 1'b1, 1'b0); expect_req("R11", 1'b0, 0);
    cyc('0,    '0, 1'b1, 1'b1); expect_req("R11", 1'b0, 0);
  endtask

  initial begin
    evt = '0; mask = '0; en = 1'b0; gnt = 1'b0; rst = 1'b1;
    t_reset();
    t_single();
    t_priority();
    t_mask();
    t_enable();
    t_merge();
    t_rearm();
    t_stray_grant();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: bench did not finish, expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule